// File: doc/BRIEF.md
# PLL Lock Monitor and Clock Control

This block decides whether a phase-locked loop has settled on its target frequency. It counts VCO clock edges over a fixed number of reference clock cycles and compares the count with the programmed multiplier times the window length. Two tolerances give the lock flag hysteresis. The flag sets when the count comes inside a narrow band. It clears only when the count leaves a wider band. A change of the flag decided by a measurement raises a sticky interrupt flag. Software clears that flag by writing 1 to it.

A seven-bit control register holds the loop enable, the mode, the filter mode, the interrupt enable and the output clock select. The same register shows the lock flag and the interrupt flag. In automatic mode the block drives the filter mode from the lock state. In manual mode software drives the filter mode, the lock flag reads 0 and no interrupt can be raised. A divide-by-four of the VCO clock forms the PLL bus clock. The output clock is either that bus clock or the reference clock. The VCO, charge pump and loop filter are outside the block; the VCO appears only as a clock input.

Top module: `pll_lock_ctrl`

## Requirements
- R1: The register bits are enable (bit 0), automatic mode (bit 1), filter tracking (bit 2), interrupt enable (bit 3), lock (bit 4, read-only), clock select (bit 5) and interrupt flag (bit 6). All of them read 0 after reset. Bits 0, 1, 3 and 5 read back the last value written. A write to bit 4 has no effect on the lock flag.
- R2: With enable=1 and automatic mode=1, the lock flag sets after a measurement whose count differs from the expected count by at most LOCK_TOL.
- R3: A set lock flag clears only after a measurement that differs from the expected count by more than UNL_TOL. A count that deviates by more than LOCK_TOL but no more than UNL_TOL leaves the flag as it is, whether it is set or clear.
- R4: With interrupt enable=1, every change of the lock flag decided by a measurement, rising or falling, sets the interrupt flag one cycle later. The irq output equals flag AND interrupt enable AND automatic mode. With interrupt enable=0, the flag is not set.
- R5: The interrupt flag stays set until a write with bit 6 = 1 clears it. A new setting event in the same cycle wins over the clear.
- R6: In manual mode (bit 1 = 0) the lock flag reads 0 from the first cycle after the mode write, and the interrupt flag is never set.
- R7: In manual mode, bit 2 takes the written value while enable=1 is also written; otherwise it reads 0. In automatic mode, bit 2 reads the lock flag and writes to it are ignored. The filt_track output follows bit 2.
- R8: Clearing the enable bit makes the lock flag and bit 2 read 0 in the next cycle, without raising an interrupt. After enable is set again, the first measurement is discarded, so the lock cannot come back within one window.
- R9: bus_clk toggles at one quarter of the VCO frequency.
- R10: clk_out carries the reference clock when bit 5 = 0 and bus_clk when bit 5 = 1.
- R11: The expected count is mult_n times WIN, so the frequency that locks follows mult_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; register and decision domain |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_vco | input | 1 | VCO output clock being measured |
| mult_n | input | NW | Frequency multiplier N |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 7 | Register write value |
| rd_data | output | 7 | Register read value |
| irq | output | 1 | Interrupt request |
| pll_en | output | 1 | Loop enable to the analog section |
| filt_track | output | 1 | Loop filter mode, 1 = tracking |
| bus_clk | output | 1 | VCO clock divided by four |
| clk_out | output | 1 | Selected output clock |

## Verification
The bench moves the VCO period between a value inside the lock band, one between the two bands and one outside both. It checks that the middle value holds whichever state it finds. A design with a single threshold would either drop lock or gain it at that middle frequency. The bench also keeps a per-cycle model of the interrupt flag. A design that flags only one direction of change, flags the silent clears caused by mode or enable writes, or lets a clear beat a new event would diverge from that model within a cycle. The bench also checks manual mode against a correctly locked VCO, a fast re-enable that must not reuse a stale count, and a change of multiplier that moves the lock point.

// File: rtl/pll_lock_pkg.sv
// Shared register layout for the PLL lock monitor.
// Assumes a seven-bit control word; the bit positions are the software contract.
package pll_lock_pkg;
    localparam int REG_W  = 7;
    localparam int B_ON   = 0;
    localparam int B_AUTO = 1;
    localparam int B_ACQ  = 2;
    localparam int B_IE   = 3;
    localparam int B_LOCK = 4;
    localparam int B_BCS  = 5;
    localparam int B_IF   = 6;
endpackage

// File: rtl/pll_vco_counter.sv
// VCO-domain edge counter. On each request toggle from the reference domain,
// it stores the count of VCO edges since the previous request, restarts the
// count and toggles the acknowledge. The snapshot stays stable until the
// next request. Also divides the VCO clock by four.
// Assumes that requests are spaced much further apart than the synchronizer delay.
module pll_vco_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk_vco,
    input  logic             rst_n,
    input  logic             req_tgl_i,
    output logic [CNT_W-1:0] snap_o,
    output logic             ack_tgl_o,
    output logic             bus_clk_o
);
    logic             vrst_s1, vrst_s2;
    logic             req_s1, req_s2, req_s3;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       div_q;

    // Bring the reset into the VCO domain
    always_ff @(posedge clk_vco) begin
        vrst_s1 <= rst_n;
        vrst_s2 <= vrst_s1;
    end

    // Count edges, take the snapshot on a request and divide the clock
    always_ff @(posedge clk_vco) begin
        if (!vrst_s2) begin
            req_s1    <= 1'b0;
            req_s2    <= 1'b0;
            req_s3    <= 1'b0;
            cnt_q     <= '0;
            snap_o    <= '0;
            ack_tgl_o <= 1'b0;
            div_q     <= '0;
        end else begin
            req_s1 <= req_tgl_i;
            req_s2 <= req_s1;
            req_s3 <= req_s2;
            div_q  <= div_q + 2'd1;
            if (req_s2 ^ req_s3) begin
                snap_o    <= cnt_q;
                cnt_q     <= CNT_W'(1);
                ack_tgl_o <= ~ack_tgl_o;
            end else if (cnt_q != '1) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign bus_clk_o = div_q[1];
endmodule

// File: rtl/pll_window_sync.sv
// Reference-domain window timer. Every WIN reference cycles it toggles a
// request to the VCO counter. When the synchronized acknowledge returns,
// it presents the snapshot as one measurement. The first measurement after
// enable is discarded because it spans time from before the enable.
module pll_window_sync #(
    parameter int WIN   = 256,
    parameter int CNT_W = 15
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] snap_i,
    input  logic             ack_tgl_i,
    output logic             req_tgl_o,
    output logic             meas_vld_o,
    output logic [CNT_W-1:0] meas_cnt_o
);
    localparam int WIN_W = $clog2(WIN);

    logic [WIN_W-1:0] win_q;
    logic             ack_s1, ack_s2, ack_s3;
    logic             primed_q;
    logic             ack_edge;

    assign ack_edge = ack_s2 ^ ack_s3;

    // Run the window, issue requests and track the discard of the first result
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            win_q     <= '0;
            req_tgl_o <= 1'b0;
            ack_s1    <= 1'b0;
            ack_s2    <= 1'b0;
            ack_s3    <= 1'b0;
            primed_q  <= 1'b0;
        end else begin
            ack_s1 <= ack_tgl_i;
            ack_s2 <= ack_s1;
            ack_s3 <= ack_s2;
            if (!en_i) begin
                win_q    <= '0;
                primed_q <= 1'b0;
            end else begin
                if (win_q == WIN_W'(WIN - 1)) begin
                    win_q     <= '0;
                    req_tgl_o <= ~req_tgl_o;
                end else begin
                    win_q <= win_q + 1'b1;
                end
                if (ack_edge) primed_q <= 1'b1;
            end
        end
    end

    assign meas_vld_o = ack_edge & primed_q & en_i;
    assign meas_cnt_o = snap_i;

    AST_NO_MEAS_ON_ENABLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(en_i) |-> !meas_vld_o); // R8
endmodule

// File: rtl/pll_lock_eval.sv
// Lock decision with hysteresis. Each measurement is compared with
// mult_i*WIN. The flag sets inside LOCK_TOL and clears outside UNL_TOL.
// chg_o pulses alongside a change that a measurement decides. A forced
// clear (en_i low) is silent. Assumes LOCK_TOL < UNL_TOL.
module pll_lock_eval #(
    parameter int WIN      = 256,
    parameter int NW       = 6,
    parameter int CNT_W    = 15,
    parameter int LOCK_TOL = 2,
    parameter int UNL_TOL  = 8
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [NW-1:0]    mult_i,
    input  logic             meas_vld_i,
    input  logic [CNT_W-1:0] meas_cnt_i,
    output logic             lock_o,
    output logic             chg_o
);
    localparam int CMPW = CNT_W + 1;

    logic [CMPW-1:0] target, meas, diff;
    logic            in_lock, out_unl;

    // Absolute deviation of the count from the target
    always_comb begin
        target  = CMPW'(mult_i) * CMPW'(WIN);
        meas    = CMPW'(meas_cnt_i);
        diff    = (meas > target) ? (meas - target) : (target - meas);
        in_lock = (diff <= CMPW'(LOCK_TOL));
        out_unl = (diff > CMPW'(UNL_TOL));
    end

    // Update the lock flag with hysteresis
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            lock_o <= 1'b0;
            chg_o  <= 1'b0;
        end else begin
            chg_o <= 1'b0;
            if (!en_i) begin
                lock_o <= 1'b0;
            end else if (meas_vld_i) begin
                if (!lock_o && in_lock) begin
                    lock_o <= 1'b1;
                    chg_o  <= 1'b1;
                end else if (lock_o && out_unl) begin
                    lock_o <= 1'b0;
                    chg_o  <= 1'b1;
                end
            end
        end
    end

    AST_LOCK_RISE_MEAS: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(lock_o) |-> $past(meas_vld_i && en_i)); // R2
    AST_LOCK_FALL_CAUSE: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $fell(lock_o) |-> $past(meas_vld_i || !en_i)); // R3
    AST_CHG_IS_EDGE: assert property (@(posedge clk_ref) disable iff (!rst_n)
        chg_o |-> (lock_o != $past(lock_o))); // R4
endmodule

// File: rtl/pll_lock_ctrl.sv
// PLL lock monitor and clock control (top). Holds the control register,
// the sticky interrupt flag and the output clock select, and connects the
// VCO counter, the window timer and the lock evaluator.
// Assumes that clk_vco runs during reset and that software changes the
// clock select only while both clocks are stable.
module pll_lock_ctrl
    import pll_lock_pkg::*;
#(
    parameter int WIN      = 256,
    parameter int NW       = 6,
    parameter int LOCK_TOL = 2,
    parameter int UNL_TOL  = 8
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             clk_vco,
    input  logic [NW-1:0]    mult_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             irq,
    output logic             pll_en,
    output logic             filt_track,
    output logic             bus_clk,
    output logic             clk_out
);
    localparam int CNT_W = NW + $clog2(WIN) + 1;

    logic             on_q, auto_q, acq_q, ie_q, bcs_q, if_q;
    logic             en, lock_w, chg, lock_rd, acq_rd, if_set;
    logic             req_tgl, ack_tgl, meas_vld;
    logic [CNT_W-1:0] snap, meas_cnt;

    assign en      = on_q & auto_q;
    assign lock_rd = lock_w & en;
    assign acq_rd  = auto_q ? lock_rd : acq_q;
    assign if_set  = chg & ie_q & en;

    pll_vco_counter #(.CNT_W(CNT_W)) u_vco_cnt (
        .clk_vco   (clk_vco),
        .rst_n     (rst_n),
        .req_tgl_i (req_tgl),
        .snap_o    (snap),
        .ack_tgl_o (ack_tgl),
        .bus_clk_o (bus_clk)
    );

    pll_window_sync #(.WIN(WIN), .CNT_W(CNT_W)) u_win (
        .clk_ref    (clk_ref),
        .rst_n      (rst_n),
        .en_i       (en),
        .snap_i     (snap),
        .ack_tgl_i  (ack_tgl),
        .req_tgl_o  (req_tgl),
        .meas_vld_o (meas_vld),
        .meas_cnt_o (meas_cnt)
    );

    pll_lock_eval #(
        .WIN(WIN), .NW(NW), .CNT_W(CNT_W),
        .LOCK_TOL(LOCK_TOL), .UNL_TOL(UNL_TOL)
    ) u_eval (
        .clk_ref    (clk_ref),
        .rst_n      (rst_n),
        .en_i       (en),
        .mult_i     (mult_n),
        .meas_vld_i (meas_vld),
        .meas_cnt_i (meas_cnt),
        .lock_o     (lock_w),
        .chg_o      (chg)
    );

    // Control register, software-owned filter bit and sticky interrupt flag
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            on_q   <= 1'b0;
            auto_q <= 1'b0;
            acq_q  <= 1'b0;
            ie_q   <= 1'b0;
            bcs_q  <= 1'b0;
            if_q   <= 1'b0;
        end else begin
            if (wr_en) begin
                on_q   <= wr_data[B_ON];
                auto_q <= wr_data[B_AUTO];
                ie_q   <= wr_data[B_IE];
                bcs_q  <= wr_data[B_BCS];
            end
            if (wr_en && !wr_data[B_AUTO]) begin
                acq_q <= wr_data[B_ACQ] & wr_data[B_ON];
            end else if (!on_q || auto_q) begin
                acq_q <= 1'b0;
            end
            if (if_set) begin
                if_q <= 1'b1;
            end else if (wr_en && wr_data[B_IF]) begin
                if_q <= 1'b0;
            end
        end
    end

    // Assemble the read value
    always_comb begin
        rd_data         = '0;
        rd_data[B_ON]   = on_q;
        rd_data[B_AUTO] = auto_q;
        rd_data[B_ACQ]  = acq_rd;
        rd_data[B_IE]   = ie_q;
        rd_data[B_LOCK] = lock_rd;
        rd_data[B_BCS]  = bcs_q;
        rd_data[B_IF]   = if_q;
    end

    assign irq        = if_q & ie_q & auto_q;
    assign pll_en     = on_q;
    assign filt_track = acq_rd;
    assign clk_out    = bcs_q ? bus_clk : clk_ref;

    AST_LOCK_WRITE_IGNORED: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (wr_en && wr_data[B_LOCK] && !lock_rd && !meas_vld) |=> !lock_rd); // R1
    AST_FLAG_STICKY: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (if_q && !(wr_en && wr_data[B_IF])) |=> if_q); // R5
    AST_MANUAL_NO_FLAG: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (!auto_q && !if_q) |=> !if_q); // R6
endmodule

// File: tb/pll_lock_ctrl_tb.sv
`timescale 1ns/1ps
module pll_lock_ctrl_tb;
    import pll_lock_pkg::*;

    localparam int WIN = 16;
    localparam int NW  = 4;
    localparam logic [REG_W-1:0] C_ON   = REG_W'(1 << B_ON);
    localparam logic [REG_W-1:0] C_AUTO = REG_W'(1 << B_AUTO);
    localparam logic [REG_W-1:0] C_ACQ  = REG_W'(1 << B_ACQ);
    localparam logic [REG_W-1:0] C_IE   = REG_W'(1 << B_IE);
    localparam logic [REG_W-1:0] C_LOCK = REG_W'(1 << B_LOCK);
    localparam logic [REG_W-1:0] C_BCS  = REG_W'(1 << B_BCS);
    localparam logic [REG_W-1:0] C_IF   = REG_W'(1 << B_IF);
    localparam int SETTLE = 10 * WIN;

    logic             clk_ref = 1'b0;
    logic             clk_vco = 1'b0;
    logic             rst_n   = 1'b0;
    logic             wr_en   = 1'b0;
    logic [REG_W-1:0] wr_data = '0;
    logic [NW-1:0]    mult_n  = NW'(4);
    logic [REG_W-1:0] rd_data;
    logic             irq, pll_en, filt_track, bus_clk, clk_out;
    real              vco_half = 0.625;

    int checks = 0, failures = 0;
    int vco_edges = 0, bus_edges = 0, out_edges = 0;

    // per-cycle model state
    bit m_on, m_auto, m_acq, m_ie, m_bcs, m_flag, prev_lock, prev_en;

    pll_lock_ctrl #(.WIN(WIN), .NW(NW), .LOCK_TOL(2), .UNL_TOL(8)) u_dut (
        .clk_ref(clk_ref), .rst_n(rst_n), .clk_vco(clk_vco), .mult_n(mult_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
        .pll_en(pll_en), .filt_track(filt_track), .bus_clk(bus_clk), .clk_out(clk_out)
    );

    always #2.5 clk_ref = ~clk_ref;
    always #(vco_half) clk_vco = ~clk_vco;

    always @(posedge clk_vco) vco_edges++;
    always @(posedge bus_clk) bus_edges++;
    always @(posedge clk_out) out_edges++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model of the registers and the flag, compared on every clock
    always @(negedge clk_ref) begin
        if (!rst_n) begin
            m_on = 0; m_auto = 0; m_acq = 0; m_ie = 0; m_bcs = 0; m_flag = 0;
            prev_lock = 0; prev_en = 0;
        end else begin
            bit cur_en, chg_now;
            chk(rd_data[B_ON] == m_on && rd_data[B_AUTO] == m_auto &&
                rd_data[B_IE] == m_ie && rd_data[B_BCS] == m_bcs,
                "R1 fields", int'(rd_data), int'({m_bcs, 1'b0, m_ie, 1'b0, m_auto, m_on}));
            chk(rd_data[B_IF] == m_flag, "R5 flag", int'(rd_data[B_IF]), int'(m_flag));
            chk(irq == (m_flag & m_ie & m_auto), "R4 irq", int'(irq), int'(m_flag & m_ie & m_auto));
            if (!m_auto) begin
                chk(rd_data[B_LOCK] == 1'b0, "R6 lock", int'(rd_data[B_LOCK]), 0);
                chk(rd_data[B_ACQ] == m_acq, "R7 acq", int'(rd_data[B_ACQ]), int'(m_acq));
            end else begin
                chk(rd_data[B_ACQ] == rd_data[B_LOCK], "R7 acq", int'(rd_data[B_ACQ]), int'(rd_data[B_LOCK]));
            end
            if (!m_on) chk(rd_data[B_LOCK] == 1'b0, "R8 lock", int'(rd_data[B_LOCK]), 0);
            chk(filt_track == rd_data[B_ACQ], "R7 pin", int'(filt_track), int'(rd_data[B_ACQ]));
            cur_en  = m_on && m_auto;
            chg_now = (rd_data[B_LOCK] != prev_lock) && prev_en && cur_en;
            if (chg_now && m_ie && cur_en) m_flag = 1;
            else if (wr_en && wr_data[B_IF]) m_flag = 0;
            if (wr_en) begin
                m_on   = wr_data[B_ON];
                m_auto = wr_data[B_AUTO];
                m_ie   = wr_data[B_IE];
                m_bcs  = wr_data[B_BCS];
                m_acq  = !wr_data[B_AUTO] ? (wr_data[B_ACQ] & wr_data[B_ON]) : 1'b0;
            end
            prev_lock = rd_data[B_LOCK];
            prev_en   = cur_en;
        end
    end

    task automatic wr(input logic [REG_W-1:0] d);
        @(posedge clk_ref); #1;
        wr_en = 1'b1; wr_data = d;
        @(posedge clk_ref); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk_ref);
        #1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk_ref);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int v0, b0, o0, dv, db, dout;
        wait_cyc(6);
        rst_n = 1'b1;
        @(negedge clk_ref);
        chk(rd_data == '0, "R1 reset", int'(rd_data), 0);
        chk(irq == 1'b0 && pll_en == 1'b0, "R1 reset pins", int'({irq, pll_en}), 0);

        // R2: lock at the nominal frequency, count 64
        wr(C_ON | C_AUTO | C_IE);
        wait_cyc(SETTLE); @(negedge clk_ref);
        chk(rd_data[B_LOCK] == 1'b1, "R2 lock in band", int'(rd_data[B_LOCK]), 1);
        chk(irq == 1'b1, "R4 rising irq", int'(irq), 1);
        chk(rd_data[B_ACQ] == 1'b1 && filt_track, "R7 auto tracking", int'(rd_data[B_ACQ]), 1);

        // R1/R7: writes to the lock and filter bits are ignored in auto mode
        wr(C_ON | C_AUTO | C_IE);
        @(negedge clk_ref);
        chk(rd_data[B_LOCK] == 1'b1, "R1 lock kept", int'(rd_data[B_LOCK]), 1);
        chk(rd_data[B_ACQ] == 1'b1, "R7 auto ignores write", int'(rd_data[B_ACQ]), 1);

        // R5: sticky flag, then clear by writing 1
        wait_cyc(40); @(negedge clk_ref);
        chk(rd_data[B_IF] == 1'b1, "R5 sticky", int'(rd_data[B_IF]), 1);
        wr(C_ON | C_AUTO | C_IE | C_IF);
        @(negedge clk_ref);
        chk(rd_data[B_IF] == 1'b0 && !irq, "R5 cleared", int'(rd_data[B_IF]), 0);

        // R3: between the bands (about 69 counts), lock held
        vco_half = 0.58;
        wait_cyc(SETTLE); @(negedge clk_ref);
        chk(rd_data[B_LOCK] == 1'b1, "R3 hold locked", int'(rd_data[B_LOCK]), 1);
        chk(rd_data[B_IF] == 1'b0, "R3 no change", int'(rd_data[B_IF]), 0);

        // R3/R4: far out (80 counts), unlock raises the flag
        vco_half = 0.5;
        wait_cyc(SETTLE); @(negedge clk_ref);
        chk(rd_data[B_LOCK] == 1'b0, "R3 unlock", int'(rd_data[B_LOCK]), 0);
        chk(rd_data[B_IF] == 1'b1 && irq, "R4 falling irq", int'(rd_data[B_IF]), 1);
        wr(C_ON | C_AUTO | C_IE | C_IF);

        // R3: between the bands while unlocked, stays unlocked; R1 lock write ignored
        vco_half = 0.58;
        wait_cyc(SETTLE);
        wr(C_ON | C_AUTO | C_IE | C_LOCK);
        @(negedge clk_ref);
        chk(rd_data[B_LOCK] == 1'b0, "R3 no entry", int'(rd_data[B_LOCK]), 0);
        chk(rd_data[B_LOCK] == 1'b0, "R1 lock write ignored", int'(rd_data[B_LOCK]), 0);

        // R4: interrupt enable 0, lock sets without flag
        wr(C_ON | C_AUTO);
        vco_half = 0.625;
        wait_cyc(SETTLE); @(negedge clk_ref);
        chk(rd_data[B_LOCK] == 1'b1, "R2 relock", int'(rd_data[B_LOCK]), 1);
        chk(rd_data[B_IF] == 1'b0 && !irq, "R4 masked", int'(rd_data[B_IF]), 0);

        // R6/R7: manual mode
        wr(C_ON | C_IE);
        @(negedge clk_ref);
        chk(rd_data[B_LOCK] == 1'b0, "R6 lock off at once", int'(rd_data[B_LOCK]), 0);
        wait_cyc(SETTLE); @(negedge clk_ref);
        chk(rd_data[B_LOCK] == 1'b0 && !irq && !rd_data[B_IF], "R6 quiet", int'(rd_data), int'(C_ON | C_IE));
        wr(C_ON | C_IE | C_ACQ);
        @(negedge clk_ref);
        chk(rd_data[B_ACQ] == 1'b1 && filt_track, "R7 manual write 1", int'(rd_data[B_ACQ]), 1);
        wr(C_ON | C_IE);
        @(negedge clk_ref);
        chk(rd_data[B_ACQ] == 1'b0, "R7 manual write 0", int'(rd_data[B_ACQ]), 0);

        // R11: multiplier 5, lock point moves to 80 counts
        #1 mult_n = NW'(5);
        vco_half = 0.5;
        wr(C_ON | C_AUTO | C_IE);
        wait_cyc(SETTLE); @(negedge clk_ref);
        chk(rd_data[B_LOCK] == 1'b1, "R11 lock at N=5", int'(rd_data[B_LOCK]), 1);
        vco_half = 0.625;
        wait_cyc(SETTLE); @(negedge clk_ref);
        chk(rd_data[B_LOCK] == 1'b0, "R11 64 counts off at N=5", int'(rd_data[B_LOCK]), 0);

        // R8: disable clears silently, re-enable discards the first window
        vco_half = 0.5;
        wait_cyc(SETTLE);
        wr(C_ON | C_AUTO | C_IE | C_IF);
        @(negedge clk_ref);
        chk(rd_data[B_LOCK] == 1'b1, "R8 locked before off", int'(rd_data[B_LOCK]), 1);
        wr(C_AUTO | C_IE);
        @(negedge clk_ref);
        chk(rd_data[B_LOCK] == 1'b0 && !rd_data[B_ACQ] && !pll_en, "R8 off clears", int'(rd_data), int'(C_AUTO | C_IE));
        wait_cyc(5); @(negedge clk_ref);
        chk(rd_data[B_IF] == 1'b0 && !irq, "R8 silent clear", int'(rd_data[B_IF]), 0);
        wr(C_ON | C_AUTO | C_IE);
        wait_cyc(WIN - 4); @(negedge clk_ref);
        chk(rd_data[B_LOCK] == 1'b0, "R8 first window discarded", int'(rd_data[B_LOCK]), 0);
        wait_cyc(SETTLE); @(negedge clk_ref);
        chk(rd_data[B_LOCK] == 1'b1, "R8 relock after enable", int'(rd_data[B_LOCK]), 1);

        // R9: bus clock is VCO/4
        v0 = vco_edges; b0 = bus_edges;
        wait_cyc(400);
        dv = vco_edges - v0; db = bus_edges - b0;
        chk((db * 4 - dv <= 4) && (dv - db * 4 <= 4), "R9 divide by four", db * 4, dv);

        // R10: output clock select
        o0 = out_edges;
        wait_cyc(200);
        dout = out_edges - o0;
        chk(dout >= 199 && dout <= 201, "R10 reference path", dout, 200);
        wr(C_ON | C_AUTO | C_IE | C_BCS);
        wait_cyc(4);
        o0 = out_edges; b0 = bus_edges;
        wait_cyc(200);
        dout = out_edges - o0; db = bus_edges - b0;
        chk(dout - db <= 1 && db - dout <= 1, "R10 PLL path", dout, db);

        finish_run();
    end
endmodule